// File: doc/BRIEF.md
# Threshold Body-Bias Loop Controller

This block closes a digital control loop around a transistor threshold voltage. A ring oscillator built as a replica of the slowest logic path runs on the same silicon, and its rate tracks how fast the real logic is at the present bias. The controller counts the replica's rising edges over a fixed window of reference-clock cycles. It compares the total with a target count, and after each window it moves a body-bias code by at most one step. A replica that runs slow means the logic is too slow, so the code steps toward less reverse bias and a lower threshold. A replica that runs fast leaves margin to spare, so the code steps toward deeper reverse bias, which raises the threshold and cuts leakage.

A narrow dead band around the target holds the code still, so the loop does not chatter once it reaches its operating point. After a run of consecutive windows inside that band, a settled flag rises. A performance-mode input requests full speed. While it is high the code is pinned at zero (no body bias, lowest threshold), the measurement stops, and the loop restarts with a fresh window when the input falls.

The replica edges arrive from a separate clock and pass through a synchronizer into the reference domain. For this reason the replica's rate must stay below half the reference rate. The bias code drives an external bias generator.

Top module: `vt_bias_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, bias_code is 0, bias_dir is 2'b00 (hold) and settled is 0.
- R2: A measurement window is WIN_LEN reference cycles long. The first window starts on the first clock edge with reset released (and performance mode low), and each following window starts right after the previous one. bias_code, bias_dir and settled change only on the edge that closes a window, or on a performance-mode entry.
- R3: If a window's replica edge count is greater than TARGET_CNT + DEAD_BAND, bias_code goes up by one (deeper reverse bias) and bias_dir becomes 2'b01.
- R4: If a window's replica edge count is less than TARGET_CNT - DEAD_BAND, bias_code goes down by one (toward no bias) and bias_dir becomes 2'b10.
- R5: If a window's count lies inside TARGET_CNT ± DEAD_BAND (bounds included), bias_code is unchanged and bias_dir becomes 2'b00.
- R6: bias_code saturates. It stays at 2^CODE_W-1 on an up decision and at 0 on a down decision, and bias_dir still reports the decision. It never wraps.
- R7: settled is 1 exactly when the last SETTLE_WINS or more completed windows all fell inside the dead band. Any window outside the band clears it.
- R8: When perf_mode is high on a clock edge, bias_code, bias_dir and settled are all 0 after that edge, and they stay 0 while perf_mode is high. Measurement is suspended, and a new full window begins on the first edge with perf_mode low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state lives in this domain |
| rst_n | input | 1 | Synchronous active-low reset |
| replica_clk | input | 1 | Critical-path replica oscillator, asynchronous to clk |
| perf_mode | input | 1 | High: full-performance demand, forces zero bias and suspends the loop |
| bias_code | output | CODE_W | Body-bias level, 0 = none, all ones = deepest reverse bias |
| bias_dir | output | 2 | Last decision: 00 hold, 01 step up, 10 step down |
| settled | output | 1 | Loop has stayed in the dead band for SETTLE_WINS windows |

## Verification
The bench builds the block with WIN_LEN = 64, TARGET_CNT = 16, DEAD_BAND = 2, SETTLE_WINS = 4 and CODE_W = 3. This keeps every window short and puts the top code, 7, only a handful of windows away, so saturation at both ends is reached cheaply. The replica is a waveform that repeats with the window period and places an exact number of rising edges away from the window edges. As a result, each window's count is known exactly, including the dead-band bounds 14 and 18 and their neighbours 13 and 19. Performance-mode entry is exercised both on a window boundary and in the middle of a window, and the restart alignment is checked by the windows that follow.

// File: rtl/vt_bias_pkg.sv
// Shared types for the threshold body-bias loop controller.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package vt_bias_pkg;

    // Decision reported per measurement window.
    typedef enum logic [1:0] {
        DIR_HOLD = 2'b00,
        DIR_UP   = 2'b01,
        DIR_DOWN = 2'b10
    } bias_dir_e;

endpackage

// File: rtl/vt_edge_sync.sv
// Brings an asynchronous oscillator into the clk domain through a chain
// of flops and emits a one-cycle pulse per rising edge.
// Assumes the input's high and low phases each last longer than one clk period.
module vt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0] chain;
    logic             last_lvl;

    // Synchronizer chain plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain    <= '0;
            last_lvl <= 1'b0;
        end else begin
            chain    <= {chain[DEPTH-2:0], async_in};
            last_lvl <= chain[DEPTH-1];
        end
    end

    // Rising edge of the synchronized level.
    always_comb rise_pulse = chain[DEPTH-1] & ~last_lvl;

endmodule

// File: rtl/vt_window_meter.sv
// Counts edge pulses over consecutive windows of WIN_LEN clk cycles.
// win_done marks the last cycle of a window; win_total then includes
// that cycle's pulse. Holding run low clears and freezes the window.
module vt_window_meter #(
    parameter int WIN_LEN = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run,
    input  logic                          edge_pulse,
    output logic                          win_done,
    output logic [$clog2(WIN_LEN+1)-1:0]  win_total
);
    localparam int CNT_W  = $clog2(WIN_LEN + 1);
    localparam int WCNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [WCNT_W-1:0] LAST = WCNT_W'(WIN_LEN - 1);

    logic [WCNT_W-1:0] cyc_cnt;
    logic [CNT_W-1:0]  edge_cnt;

    // End-of-window strobe and the completed total.
    always_comb begin
        win_done  = run && (cyc_cnt == LAST);
        win_total = edge_cnt + CNT_W'(edge_pulse);
    end

    // Window position and running edge tally.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || win_done) begin
            cyc_cnt  <= '0;
            edge_cnt <= '0;
        end else begin
            cyc_cnt  <= cyc_cnt + 1'b1;
            edge_cnt <= edge_cnt + CNT_W'(edge_pulse);
        end
    end

endmodule

// File: rtl/vt_bias_stepper.sv
// Turns each window total into a bang-bang decision, steps a saturating
// bias code, and tracks consecutive in-band windows for the settled flag.
// Assumes win_done is a single-cycle strobe.
module vt_bias_stepper
    import vt_bias_pkg::*;
#(
    parameter int WIN_LEN     = 256,
    parameter int TARGET_CNT  = 64,
    parameter int DEAD_BAND   = 2,
    parameter int SETTLE_WINS = 4,
    parameter int CODE_W      = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          force_zero,
    input  logic                          win_done,
    input  logic [$clog2(WIN_LEN+1)-1:0]  win_total,
    output logic [CODE_W-1:0]             bias_code,
    output bias_dir_e                     bias_dir,
    output logic                          settled
);
    localparam int BAND_HI = TARGET_CNT + DEAD_BAND;
    localparam int BAND_LO = TARGET_CNT - DEAD_BAND;
    localparam int SC_W    = $clog2(SETTLE_WINS + 1);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [SC_W-1:0]   SC_FULL  = SC_W'(SETTLE_WINS);

    bias_dir_e       decision;
    logic [SC_W-1:0] calm_cnt;
    int              total_i;

    // Compare the window total against the dead band.
    always_comb begin
        total_i = int'(win_total);
        if (total_i > BAND_HI)      decision = DIR_UP;
        else if (total_i < BAND_LO) decision = DIR_DOWN;
        else                        decision = DIR_HOLD;
    end

    // Saturating code step and decision register.
    always_ff @(posedge clk) begin
        if (!rst_n || force_zero) begin
            bias_code <= '0;
            bias_dir  <= DIR_HOLD;
        end else if (win_done) begin
            bias_dir <= decision;
            if (decision == DIR_UP && bias_code != CODE_MAX)
                bias_code <= bias_code + 1'b1;
            else if (decision == DIR_DOWN && bias_code != '0)
                bias_code <= bias_code - 1'b1;
        end
    end

    // Run length of consecutive in-band windows, saturating at SETTLE_WINS.
    always_ff @(posedge clk) begin
        if (!rst_n || force_zero) begin
            calm_cnt <= '0;
        end else if (win_done) begin
            if (decision != DIR_HOLD)  calm_cnt <= '0;
            else if (calm_cnt != SC_FULL) calm_cnt <= calm_cnt + 1'b1;
        end
    end

    // Settled once the run length is reached.
    always_comb settled = (calm_cnt == SC_FULL);

endmodule

// File: rtl/vt_bias_ctrl.sv
// Top of the threshold body-bias loop. Synchronizes the replica oscillator,
// measures it per window, and steps the bias code. perf_mode pins the code
// at zero and suspends measurement. perf_mode is assumed synchronous to clk.
module vt_bias_ctrl
    import vt_bias_pkg::*;
#(
    parameter int WIN_LEN     = 256,
    parameter int TARGET_CNT  = 64,
    parameter int DEAD_BAND   = 2,
    parameter int SETTLE_WINS = 4,
    parameter int CODE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              replica_clk,
    input  logic              perf_mode,
    output logic [CODE_W-1:0] bias_code,
    output logic [1:0]        bias_dir,
    output logic              settled
);
    localparam int CNT_W = $clog2(WIN_LEN + 1);

    logic             rep_rise;
    logic             win_done;
    logic [CNT_W-1:0] win_total;
    bias_dir_e        dir_q;

    vt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (replica_clk),
        .rise_pulse(rep_rise)
    );

    vt_window_meter #(.WIN_LEN(WIN_LEN)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (~perf_mode),
        .edge_pulse(rep_rise),
        .win_done  (win_done),
        .win_total (win_total)
    );

    vt_bias_stepper #(
        .WIN_LEN    (WIN_LEN),
        .TARGET_CNT (TARGET_CNT),
        .DEAD_BAND  (DEAD_BAND),
        .SETTLE_WINS(SETTLE_WINS),
        .CODE_W     (CODE_W)
    ) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_zero(perf_mode),
        .win_done  (win_done),
        .win_total (win_total),
        .bias_code (bias_code),
        .bias_dir  (dir_q),
        .settled   (settled)
    );

    // Present the decision as a plain two-bit port.
    always_comb bias_dir = dir_q;

endmodule

// File: rtl/vt_bias_ctrl_chk.sv
// Property checker for vt_bias_ctrl, attached by bind below.
module vt_bias_ctrl_chk #(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              perf_mode,
    input logic              win_done,
    input logic [CODE_W-1:0] bias_code,
    input logic [1:0]        bias_dir,
    input logic              settled
);
    localparam logic [CODE_W-1:0] TOP = '1;

    // R1: reset clears every output
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (bias_code == '0 && bias_dir == 2'b00 && !settled));

    // R8: performance mode pins outputs at zero after the edge
    a_r8_perf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        perf_mode |=> (bias_code == '0 && bias_dir == 2'b00 && !settled));

    // R2: outside a window end the code does not move
    a_r2_hold_mid_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!perf_mode && !win_done) |=> $stable(bias_code));

    // R3/R4: a step is never larger than one level
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !perf_mode |=> (int'(bias_code) <= int'($past(bias_code)) + 1 &&
                        int'(bias_code) + 1 >= int'($past(bias_code))));

    // R6: no wrap from the top code to zero
    a_r6_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
        (!perf_mode && bias_code == TOP) |=> bias_code != '0);

    // R6: no wrap from zero to the top code
    a_r6_no_wrap_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (!perf_mode && bias_code == '0) |=> bias_code != TOP);

    // R7: a settled loop last reported a hold decision
    a_r7_settled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        settled |-> bias_dir == 2'b00);

    // R5: direction field only takes defined codes
    a_r5_dir_legal: assert property (@(posedge clk) disable iff (!rst_n)
        bias_dir != 2'b11);

endmodule

bind vt_bias_ctrl vt_bias_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .perf_mode(perf_mode),
    .win_done (win_done),
    .bias_code(bias_code),
    .bias_dir (bias_dir),
    .settled  (settled)
);

// File: tb/tb_vt_bias_ctrl.sv
// Directed bench for vt_bias_ctrl. The replica waveform repeats with the
// window period so each window holds an exact, known edge count.
module tb_vt_bias_ctrl;
    localparam int W      = 64;
    localparam int TGT    = 16;
    localparam int DB     = 2;
    localparam int SET_N  = 4;
    localparam int CW     = 3;
    localparam int TOPC   = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          replica_clk = 1'b0;
    logic          perf_mode = 1'b0;
    logic [CW-1:0] bias_code;
    logic [1:0]    bias_dir;
    logic          settled;

    int n_tests = 0;
    int n_fail  = 0;
    int phase   = 0;
    int rep_n   = 0;
    int exp_code = 0, exp_dir = 0, exp_sc = 0;

    vt_bias_ctrl #(
        .WIN_LEN(W), .TARGET_CNT(TGT), .DEAD_BAND(DB),
        .SETTLE_WINS(SET_N), .CODE_W(CW), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .replica_clk(replica_clk),
        .perf_mode(perf_mode), .bias_code(bias_code),
        .bias_dir(bias_dir), .settled(settled)
    );

    always #5 clk = ~clk;

    // Bench's own window position, per R2 and R8.
    always @(posedge clk) begin
        if (!rst_n || perf_mode) phase <= 0;
        else                     phase <= (phase + 1) % W;
    end

    // Replica: rep_n one-cycle pulses at positions 4,6,... within a window.
    always @(posedge clk) begin
        replica_clk <= (phase >= 4) && (phase < 4 + 2 * rep_n) && (phase % 2 == 0);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check(int'(bias_code) == exp_code, req, "bias_code", int'(bias_code), exp_code);
        check(int'(bias_dir) == exp_dir, req, "bias_dir", int'(bias_dir), exp_dir);
        check(int'(settled) == int'(exp_sc == SET_N), req, "settled",
              int'(settled), int'(exp_sc == SET_N));
    endtask

    // One full window with n replica edges; called at a window boundary.
    task automatic run_window(input int n, input string req);
        rep_n = n;
        do @(negedge clk); while (phase != W / 2);
        check(int'(bias_code) == exp_code, "R2", "mid-window code",
              int'(bias_code), exp_code);
        do @(negedge clk); while (phase != 0);
        if (n > TGT + DB) begin
            exp_dir = 1; exp_sc = 0;
            if (exp_code < TOPC) exp_code++;
        end else if (n < TGT - DB) begin
            exp_dir = 2; exp_sc = 0;
            if (exp_code > 0) exp_code--;
        end else begin
            exp_dir = 0;
            if (exp_sc < SET_N) exp_sc++;
        end
        check_outputs(req);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        exp_code = 0; exp_dir = 0; exp_sc = 0;
        check_outputs("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1");
        do @(negedge clk); while (phase != 0);
    endtask

    task automatic t_fast();
        for (int i = 0; i < 3; i++) run_window(24, "R3");
    endtask

    task automatic t_band_edges();
        run_window(19, "R3");
        run_window(18, "R5");
        run_window(14, "R5");
        run_window(13, "R4");
    endtask

    task automatic t_settle();
        for (int i = 0; i < 3; i++) run_window(16, "R7");
        check(settled == 1'b0, "R7", "not yet settled", int'(settled), 0);
        run_window(17, "R7");
        check(settled == 1'b1, "R7", "settled after run", int'(settled), 1);
        run_window(16, "R7");
        run_window(25, "R7");
        check(settled == 1'b0, "R7", "cleared by step", int'(settled), 0);
    endtask

    task automatic t_top_sat();
        for (int i = 0; i < 6; i++) run_window(28, "R6");
        check(int'(bias_code) == TOPC, "R6", "top code held", int'(bias_code), TOPC);
    endtask

    task automatic t_perf(input int at_phase);
        do @(negedge clk); while (phase != at_phase);
        perf_mode = 1'b1;
        @(negedge clk);
        exp_code = 0; exp_dir = 0; exp_sc = 0;
        check_outputs("R8");
        repeat (2 * W + 7) @(negedge clk);
        check_outputs("R8");
        perf_mode = 1'b0;
    endtask

    task automatic t_floor_sat();
        for (int i = 0; i < 3; i++) run_window(4, "R6");
        check(int'(bias_code) == 0, "R6", "floor code held", int'(bias_code), 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fast();
        t_band_edges();
        t_settle();
        t_top_sat();
        t_perf(0);
        t_floor_sat();
        run_window(30, "R3");
        run_window(30, "R3");
        t_perf(20);
        run_window(22, "R8");
        run_window(22, "R8");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule